// File: doc/BRIEF.md
# Tuner Synthesizer Control Port

This block is the two-wire serial target that holds the programming state of a frequency-synthesizer front end. The system clock oversamples the serial clock and data lines. The block detects bus start and stop conditions and compares the address byte against its own address. It acknowledges each byte it accepts. It then routes written data into three register groups: a 15-bit loop divider word, a 7-bit control field and a 3-bit band-port field.

Write data arrives in pairs of bytes. The top bit of the first byte in each pair picks the pair's kind, so the divider pair and the control/band pair may appear in either order within one transaction. A read returns a status byte that carries a power-on flag and the loop lock indication. The power-on flag is set by reset or by a supply-low event and is cleared when a read transaction ends. While the supply-low event input is active, the block never pulls the data line low.

Top module: `tuner_i2c_regs`

## Requirements
- R1: A START (data falls while clock is high) begins address decoding at any time. A STOP (data rises while clock is high) returns the block to idle with the data line released.
- R2: The device address is the 7-bit value {5'b11000, addr_sel_i[1], addr_sel_i[0]}, followed by the R/W bit (0 = write, 1 = read). On a match the block pulls the data line low for the ninth clock. On a mismatch it acknowledges nothing and ignores the bus until the next START.
- R3: A write pair whose first byte has bit 7 = 0 loads div_o = {first[6:0], second[7:0]}. div_o changes only once the second byte has been acknowledged, and it never takes a partial value.
- R4: A write pair whose first byte has bit 7 = 1 loads ctrl_o = first[6:0] (bit 6 charge-pump current, bits 5:4 test mode, bit 3 spare, bits 2:1 reference ratio select, bit 0 tuning-output disable) and band_o = second[2:0]. Both fields update when the second byte has been acknowledged.
- R5: Pairs of either kind may follow one another in any order within a single transaction. A first byte that has no second byte before the next START or STOP changes no register.
- R6: After a matching read address, the block sends the status byte MSB first: bit 7 = power-on flag, bit 6 = lock_i, bits 5:0 = 0. It sends it again each time the controller acknowledges. After a controller not-acknowledge, it releases the data line.
- R7: por_flag_o is 1 after reset and after any cycle with por_evt_i high. It clears when a read transaction ends, either by STOP or by a repeated START.
- R8: sda_pull_o is never 1 while por_evt_i is 1.
- R9: A repeated START in the middle of a transaction restarts address decoding. The new address and direction then take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line sample |
| sda_i | input | 1 | Serial data line sample |
| addr_sel_i | input | 2 | Low two bits of the device address |
| lock_i | input | 1 | Loop lock indication reported in status |
| por_evt_i | input | 1 | Power-on / supply-low event |
| sda_pull_o | output | 1 | Data line pull-down enable |
| div_o | output | 15 | Loop divider word |
| ctrl_o | output | 7 | Control field |
| band_o | output | 3 | Band-port outputs |
| por_flag_o | output | 1 | Power-on flag |

## Verification
The hardest states to reach are the ones inside a transaction. One is the gap between the two bytes of a divider pair, where the divider must still hold its old value. Another is the end of a read closed by a repeated START rather than a STOP, which must still clear the power-on flag. The stimulus reaches the first by pausing after the leading byte and sampling div_o before the second byte is sent. It reaches the second by chaining a write, a repeated START into a read, and another repeated START to a foreign address. A full sweep of the four address-select settings against four target addresses covers matching and rejection.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int LEAD_W = BYTE_W - 1;
  localparam int DIV_W  = LEAD_W + BYTE_W;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status,
  output logic              drive_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              rd_end_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              drive_q, drive_d;
  logic              rd_q, rd_d;
  logic              more_q, more_d;
  logic              vld_q, vld_d;
  logic              rd_end_q, rd_end_d;
  logic [6:0]        own_addr;

  assign own_addr = {ADDR_HI, addr_sel};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    drive_d  = drive_q;
    rd_d     = rd_q;
    more_d   = more_q;
    vld_d    = 1'b0;
    rd_end_d = 1'b0;
    if (start_p) begin
      state_d  = ST_ADDR;
      cnt_d    = '0;
      drive_d  = 1'b0;
      rd_d     = 1'b0;
      rd_end_d = rd_q;
    end else if (stop_p) begin
      state_d  = ST_IDLE;
      drive_d  = 1'b0;
      rd_d     = 1'b0;
      rd_end_d = rd_q;
    end else begin
      case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            cnt_d = '0;
            if (state_q == ST_WDATA) begin
              state_d = ST_WACK;
              drive_d = 1'b1;
            end else if (sh_q[BYTE_W-1:1] == own_addr) begin
              state_d = ST_AACK;
              drive_d = 1'b1;
              rd_d    = sh_q[0];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              state_d = ST_RDATA;
              tx_d    = status;
              drive_d = ~status[BYTE_W-1];
            end else begin
              state_d = ST_WDATA;
              drive_d = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            drive_d = 1'b0;
            vld_d   = 1'b1;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RACK;
              drive_d = 1'b0;
              cnt_d   = '0;
            end else begin
              tx_d    = {tx_q[BYTE_W-2:0], 1'b0};
              drive_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more_d = ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              state_d = ST_RDATA;
              tx_d    = status;
              drive_d = ~status[BYTE_W-1];
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      drive_q  <= 1'b0;
      rd_q     <= 1'b0;
      more_q   <= 1'b0;
      vld_q    <= 1'b0;
      rd_end_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      drive_q  <= drive_d;
      rd_q     <= rd_d;
      more_q   <= more_d;
      vld_q    <= vld_d;
      rd_end_q <= rd_end_d;
    end
  end

  assign drive_o    = drive_q;
  assign byte_o     = sh_q;
  assign byte_vld_o = vld_q;
  assign rd_end_o   = rd_end_q;

  assert_drive_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> (state_q == ST_AACK || state_q == ST_WACK || state_q == ST_RDATA));
  assert_start_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (state_q == ST_ADDR && cnt_q == '0));
  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && !start_p) |=> (state_q == ST_IDLE && !drive_q));
  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !drive_q);
endmodule

// File: rtl/tuner_i2c_regfile.sv
module tuner_i2c_regfile
  import tuner_i2c_pkg::*;
#(
  parameter int BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_end,
  input  logic              por_evt,
  input  logic              lock,
  output logic [DIV_W-1:0]  div_o,
  output logic [LEAD_W-1:0] ctrl_o,
  output logic [BAND_W-1:0] band_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              por_o
);
  logic              pend_q, pend_d;
  logic              kind_q, kind_d;
  logic [LEAD_W-1:0] hold_q, hold_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [LEAD_W-1:0] ctrl_q, ctrl_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic              por_q, por_d;

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    hold_d = hold_q;
    div_d  = div_q;
    ctrl_d = ctrl_q;
    band_d = band_q;
    if (txn_start) begin
      pend_d = 1'b0;
    end else if (byte_vld) begin
      if (!pend_q) begin
        pend_d = 1'b1;
        kind_d = byte_i[BYTE_W-1];
        hold_d = byte_i[LEAD_W-1:0];
      end else begin
        pend_d = 1'b0;
        if (kind_q) begin
          ctrl_d = hold_q;
          band_d = byte_i[BAND_W-1:0];
        end else begin
          div_d = {hold_q, byte_i};
        end
      end
    end
    if (por_evt)     por_d = 1'b1;
    else if (rd_end) por_d = 1'b0;
    else             por_d = por_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= 1'b0;
      hold_q <= '0;
      div_q  <= '0;
      ctrl_q <= '0;
      band_q <= '0;
      por_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
      hold_q <= hold_d;
      div_q  <= div_d;
      ctrl_q <= ctrl_d;
      band_q <= band_d;
      por_q  <= por_d;
    end
  end

  assign div_o    = div_q;
  assign ctrl_o   = ctrl_q;
  assign band_o   = band_q;
  assign por_o    = por_q;
  assign status_o = {por_q, lock, {(BYTE_W-2){1'b0}}};

  assert_div_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> $past(byte_vld && pend_q && !kind_q && !txn_start));
  assert_band_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (band_q != $past(band_q)) |-> $past(byte_vld && pend_q && kind_q && !txn_start));
  assert_por_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_q) |-> $past(por_evt));
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b11000,
  parameter int         SYNC_STAGES = 2,
  parameter int         BAND_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic              por_evt_i,
  output logic              sda_pull_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [LEAD_W-1:0] ctrl_o,
  output logic [BAND_W-1:0] band_o,
  output logic              por_flag_o
);
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_p;
  logic              stop_p;
  logic              drive;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_vld;
  logic              rd_end;
  logic [BYTE_W-1:0] status;

  tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  tuner_i2c_engine #(.ADDR_HI(ADDR_HI)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .addr_sel   (addr_sel_i),
    .status     (status),
    .drive_o    (drive),
    .byte_o     (rx_byte),
    .byte_vld_o (rx_vld),
    .rd_end_o   (rd_end)
  );

  tuner_i2c_regfile #(.BAND_W(BAND_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_start (start_p),
    .byte_vld  (rx_vld),
    .byte_i    (rx_byte),
    .rd_end    (rd_end),
    .por_evt   (por_evt_i),
    .lock      (lock_i),
    .div_o     (div_o),
    .ctrl_o    (ctrl_o),
    .band_o    (band_o),
    .status_o  (status),
    .por_o     (por_flag_o)
  );

  assign sda_pull_o = drive & ~por_evt_i;
endmodule

// File: tb/tuner_i2c_regs_bench.sv
module tuner_i2c_regs_bench;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic [1:0]  addr_sel;
  logic        lock;
  logic        por_evt;
  logic        sda_pull;
  logic [14:0] div;
  logic [6:0]  ctrl;
  logic [2:0]  band;
  logic        por_flag;
  wire         sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int fails = 0;
  int pull_in_por = 0;

  always #5 clk = ~clk;

  tuner_i2c_regs u_tuner_i2c_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .addr_sel_i (addr_sel),
    .lock_i     (lock),
    .por_evt_i  (por_evt),
    .sda_pull_o (sda_pull),
    .div_o      (div),
    .ctrl_o     (ctrl),
    .band_o     (band),
    .por_flag_o (por_flag)
  );

  always @(negedge clk) if (por_evt && sda_pull) pull_in_por++;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = ~sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0;
    end
    tick(2);
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    bit          ack;
    logic [7:0]  rb;
    logic [14:0] exp_div;
    logic [6:0]  exp_ctrl;
    logic [2:0]  exp_band;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    addr_sel = 2'b01; lock = 1'b0; por_evt = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // Reset state (R7 flag set, registers cleared)
    check(div == 0, "R3", "reset div", div, 0);
    check(ctrl == 0 && band == 0, "R4", "reset ctrl/band", {ctrl, band}, 0);
    check(por_flag == 1, "R7", "reset por flag", por_flag, 1);
    check(sda_pull == 0, "R1", "reset sda release", sda_pull, 0);

    // R8: event active, matching address must not be acknowledged
    por_evt = 1'b1;
    i2c_start();
    send_byte({5'b11000, 2'b01, 1'b0}, ack);
    check(!ack, "R8", "ack during power event", ack, 0);
    send_byte(8'h12, ack);
    i2c_stop();
    check(pull_in_por == 0, "R8", "pull count during event", pull_in_por, 0);
    por_evt = 1'b0;
    tick(3);
    check(div == 0, "R8", "div after silent write", div, 0);

    // R2/R3: sweep of select pins against target addresses
    exp_div = '0;
    for (int sel = 0; sel < 4; sel++) begin
      addr_sel = 2'(sel);
      for (int tgt = 0; tgt < 4; tgt++) begin
        logic [14:0] dv;
        dv = 15'((sel * 4 + tgt) * 1933 + 300);
        i2c_start();
        send_byte({5'b11000, 2'(tgt), 1'b0}, ack);
        check(ack == (sel == tgt), "R2", "address ack", ack, (sel == tgt));
        send_byte({1'b0, dv[14:8]}, ack);
        check(ack == (sel == tgt), "R2", "data ack", ack, (sel == tgt));
        send_byte(dv[7:0], ack);
        i2c_stop();
        tick(3);
        if (sel == tgt) exp_div = dv;
        check(div == exp_div, "R3", "divider after pair", div, exp_div);
      end
    end

    // R2: wrong upper address bits
    addr_sel = 2'b10;
    i2c_start();
    send_byte({5'b10000, 2'b10, 1'b0}, ack);
    check(!ack, "R2", "foreign upper bits", ack, 0);
    i2c_stop();

    // R3: divider holds between its two bytes
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'h55, ack);
    tick(4);
    check(div == exp_div, "R3", "div between bytes", div, exp_div);
    send_byte(8'hA9, ack);
    tick(3);
    exp_div = 15'h55A9;
    check(div == exp_div, "R3", "div after second byte", div, exp_div);
    i2c_stop();

    // R4/R5: control pair then divider pair
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'hDA, ack);
    send_byte(8'hF5, ack);
    send_byte(8'h12, ack);
    send_byte(8'h34, ack);
    i2c_stop();
    tick(3);
    exp_ctrl = 7'h5A; exp_band = 3'd5; exp_div = 15'h1234;
    check(ctrl == exp_ctrl, "R4", "ctrl from leader", ctrl, exp_ctrl);
    check(band == exp_band, "R4", "band low bits", band, exp_band);
    check(div == exp_div, "R5", "div after ctrl pair", div, exp_div);

    // R5: divider pair then control pair
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'h7F, ack);
    send_byte(8'hFF, ack);
    send_byte(8'h81, ack);
    send_byte(8'h02, ack);
    i2c_stop();
    tick(3);
    exp_ctrl = 7'h01; exp_band = 3'd2; exp_div = 15'h7FFF;
    check(div == exp_div, "R5", "div first order", div, exp_div);
    check(ctrl == exp_ctrl && band == exp_band, "R5", "ctrl/band second", {ctrl, band}, {exp_ctrl, exp_band});

    // R5: lone leaders are discarded
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'hBF, ack);
    i2c_stop();
    tick(3);
    check(ctrl == exp_ctrl, "R5", "lone control leader", ctrl, exp_ctrl);
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'h11, ack);
    i2c_stop();
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'hC3, ack);
    send_byte(8'h06, ack);
    i2c_stop();
    tick(3);
    exp_ctrl = 7'h43; exp_band = 3'd6;
    check(div == exp_div, "R5", "lone divider leader", div, exp_div);
    check(ctrl == exp_ctrl && band == exp_band, "R5", "pairing restarts", {ctrl, band}, {exp_ctrl, exp_band});

    // R6/R7: status read, repeated while acknowledged
    lock = 1'b1;
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b1}, ack);
    check(ack, "R6", "read address ack", ack, 1);
    recv_byte(1'b1, rb);
    check(rb == 8'hC0, "R6", "status byte 1", rb, 8'hC0);
    recv_byte(1'b0, rb);
    check(rb == 8'hC0, "R6", "status byte 2", rb, 8'hC0);
    tick(2);
    check(sda_pull == 0, "R6", "release after nack", sda_pull, 0);
    check(por_flag == 1, "R7", "flag held until end", por_flag, 1);
    i2c_stop();
    tick(3);
    check(por_flag == 0, "R7", "flag cleared by stop", por_flag, 0);
    lock = 1'b0;
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b1}, ack);
    recv_byte(1'b0, rb);
    i2c_stop();
    check(rb == 8'h00, "R6", "status after clear", rb, 8'h00);

    // R7 event, R9 repeated start into read, then end read by repeated start
    por_evt = 1'b1; tick(3); por_evt = 1'b0; tick(3);
    check(por_flag == 1, "R7", "flag set by event", por_flag, 1);
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b0}, ack);
    send_byte(8'h85, ack);
    send_byte(8'h01, ack);
    i2c_start();
    send_byte({5'b11000, 2'b10, 1'b1}, ack);
    check(ack, "R9", "read after repeated start", ack, 1);
    recv_byte(1'b0, rb);
    check(rb == 8'h80, "R9", "status after repeated start", rb, 8'h80);
    i2c_start();
    send_byte({5'b11000, 2'b01, 1'b0}, ack);
    check(!ack, "R9", "foreign address after restart", ack, 0);
    tick(3);
    check(por_flag == 0, "R7", "flag cleared by restart", por_flag, 0);
    i2c_stop();
    tick(3);
    check(ctrl == 7'h05 && band == 3'd1, "R4", "ctrl before restart", {ctrl, band}, {7'h05, 3'd1});
    report();
  end
endmodule